// File: doc/BRIEF.md
# Port Interrupt Status and Mask Controller

This block gathers the thirty-two interrupt sources of one PCIe port into a single interrupt line. The four lowest sources are the legacy INTx wires. They are level-sensitive, and their status bits follow the live input. The remaining twenty-eight sources are event signals. A rising edge on one of them latches its status bit, and the bit stays set until software writes a one to it.

Software reaches the block through a small word-addressed register bus. Writes take effect on the clock edge. Reads are combinational from the current register contents. The mask register cannot be written directly. It changes only through a mask-set port and a mask-clear port.

A typical start-up writes all ones to mask-set and then all ones to the status port. Every source then begins masked and cleared. The combined interrupt output is the registered OR of the pending bits that are not masked.

Some event bits have fixed positions:
- bandwidth management: 11
- link up: 12
- link down: 14
- port error: 4
- error-reporting group: 4 to 7
- MSI error: 18
- completion abort: 21
- ID-map error: 22
- completion timeout: 23

Top module: `pirq_ctrl`

## Requirements
- R1: During and after a synchronous active-low reset, the status register reads 0, the mask reads all ones, and `irq_o` is 0.
- R2: Status bits 0 to 3 equal the level of `src_i[3:0]` sampled at the previous clock edge. A one written to them at address 0 has no effect.
- R3: For bits 4 to 31, a rising edge on the source sets the status bit at the next edge. Here a rising edge means the input is 1 at this edge and was 0 at the previous edge, or is the first 1 after reset. The bit stays set after the source falls.
- R4: A write to address 0 clears every bit from 4 to 31 whose data bit is 1. Bits whose data bit is 0 keep their value.
- R5: When a rising edge and a clearing write reach the same event bit in the same cycle, the bit ends up set.
- R6: A write to address 2 sets the mask bits that are 1 in the data, and a write to address 3 clears them. A write to address 1 leaves the mask unchanged.
- R7: `irq_o` is the OR over all bits of (status AND NOT mask) one cycle earlier. It therefore changes one edge after the status or the mask changes.
- R8: `bus_rdata` shows the status when `bus_addr` is 0, and the mask when `bus_addr` is 1, 2 or 3. It follows the address combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 32 | Interrupt sources. Bits 3:0 are level INTx, the rest are edge events |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 2 | Word address: 0 status, 1 mask, 2 mask-set, 3 mask-clear |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_o | output | 1 | Combined interrupt, registered |

## Verification
The sources are driven with several distinct patterns, each chosen to separate a specific behaviour:
- Held INTx levels followed by a clear attempt distinguish mirrored bits from latched ones.
- Single-cycle pulses on event bits show that the latch holds the bit once the source falls.
- A source held high must not re-latch after it has been cleared.
- A rising edge that coincides with a clearing write separates set-wins from clear-wins.

Mask traffic is exercised in three ways:
- separate set and clear writes;
- a write to the direct mask address, which must be ignored;
- unmasking single pending bits, which shows the one-cycle lag of the interrupt output.

A behavioural model is compared against the reads and the interrupt on every clock.

// File: rtl/pirq_pkg.sv
// Package: shared address map and fixed event positions for the port
// interrupt controller. Assumes a word-addressed bus with two address bits.
package pirq_pkg;
    localparam int ADDR_W        = 2;
    localparam logic [ADDR_W-1:0] A_STATUS  = 2'd0;
    localparam logic [ADDR_W-1:0] A_MASK    = 2'd1;
    localparam logic [ADDR_W-1:0] A_MASKSET = 2'd2;
    localparam logic [ADDR_W-1:0] A_MASKCLR = 2'd3;

    localparam int BIT_PORT_ERR  = 4;
    localparam int BIT_BWMGMT    = 11;
    localparam int BIT_LINK_UP   = 12;
    localparam int BIT_LINK_DOWN = 14;
    localparam int BIT_MSI_ERR   = 18;
    localparam int BIT_CPL_ABORT = 21;
    localparam int BIT_IDMAP_ERR = 22;
    localparam int BIT_CPL_TMO   = 23;
endpackage

// File: rtl/pirq_src_latch.sv
// Module: per-source status capture. The low NUM_LEVEL bits mirror their
// inputs through one register. The higher bits latch on a rising edge and
// clear on a clear strobe; set wins over clear. Assumes sources are
// synchronous to clk.
module pirq_src_latch #(
    parameter int NUM_SRC   = 32,
    parameter int NUM_LEVEL = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] status_o
);
    logic [NUM_SRC-1:0] src_q;
    logic [NUM_SRC-1:0] rise;

    // Purpose: remember last source sample for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src_i;
    end

    assign rise = src_i & ~src_q;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        if (i < NUM_LEVEL) begin : g_level
            // Purpose: level bit follows its input, one register delay
            always_ff @(posedge clk) begin
                if (!rst_n) status_o[i] <= 1'b0;
                else        status_o[i] <= src_i[i];
            end

            // R2: mirrored level, unaffected by clears
            p_level_mirror_r2: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> status_o[i] == $past(src_i[i]));
        end else begin : g_edge
            // Purpose: latch rising edge, clear on strobe, set has priority
            always_ff @(posedge clk) begin
                if (!rst_n)        status_o[i] <= 1'b0;
                else if (rise[i])  status_o[i] <= 1'b1;
                else if (clr_i[i]) status_o[i] <= 1'b0;
            end

            // R3: an edge latches the bit
            p_edge_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
                rise[i] |=> status_o[i]);

            // R4: a clear without an edge empties the bit
            p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_i[i] && !rise[i]) |=> !status_o[i]);

            // R5: a simultaneous edge and clear leave the bit set
            p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_i[i] && rise[i]) |=> status_o[i]);
        end
    end
endmodule

// File: rtl/pirq_mask_reg.sv
// Module: mask register changed only through set and clear strobes.
// Set wins if both hit one bit. Assumes at most one strobe source per cycle
// from the decoder, but tolerates both.
module pirq_mask_reg #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] mask_o
);
    // Purpose: apply set/clear strobes; reset masks everything
    always_ff @(posedge clk) begin
        if (!rst_n) mask_o <= '1;
        else        mask_o <= (mask_o & ~clr_i) | set_i;
    end

    // R6: set strobes mask their bits
    p_mask_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((mask_o & $past(set_i)) == $past(set_i)));

    // R6: clear strobes unmask their bits
    p_mask_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i != '0) |=> ((mask_o & $past(clr_i & ~set_i)) == '0));

    // R6: without strobes the mask holds
    p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i == '0 && clr_i == '0) |=> $stable(mask_o));
endmodule

// File: rtl/pirq_irq_out.sv
// Module: registered reduction of unmasked pending bits into one interrupt.
// Assumes status and mask are both registered upstream.
module pirq_irq_out #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] status_i,
    input  logic [NUM_SRC-1:0] mask_i,
    output logic               irq_o
);
    logic [NUM_SRC-1:0] pend;
    assign pend = status_i & ~mask_i;

    // Purpose: register the OR of pending, unmasked sources
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= |pend;
    end

    // R7: no interrupt one cycle after nothing was pending
    p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_i & ~mask_i) == '0) |=> !irq_o);

    // R7: interrupt one cycle after something was pending
    p_irq_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_i & ~mask_i) != '0) |=> irq_o);
endmodule

// File: rtl/pirq_ctrl.sv
// Module: top of the port interrupt controller. Decodes the register bus
// into clear, mask-set and mask-clear strobes and muxes read data.
// Assumes a single-cycle write strobe and combinational reads.
module pirq_ctrl
    import pirq_pkg::*;
#(
    parameter int NUM_SRC   = 32,
    parameter int NUM_LEVEL = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [NUM_SRC-1:0] bus_wdata,
    output logic [NUM_SRC-1:0] bus_rdata,
    output logic               irq_o
);
    logic [NUM_SRC-1:0] status;
    logic [NUM_SRC-1:0] mask;
    logic [NUM_SRC-1:0] st_clr;
    logic [NUM_SRC-1:0] mk_set;
    logic [NUM_SRC-1:0] mk_clr;

    // Purpose: turn bus writes into per-bit strobes
    always_comb begin
        st_clr = '0;
        mk_set = '0;
        mk_clr = '0;
        if (bus_we) begin
            unique case (bus_addr)
                A_STATUS:  st_clr = bus_wdata;
                A_MASKSET: mk_set = bus_wdata;
                A_MASKCLR: mk_clr = bus_wdata;
                default:   ;
            endcase
        end
    end

    pirq_src_latch #(.NUM_SRC(NUM_SRC), .NUM_LEVEL(NUM_LEVEL)) u_latch (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .clr_i(st_clr), .status_o(status));

    pirq_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
        .clk(clk), .rst_n(rst_n), .set_i(mk_set), .clr_i(mk_clr), .mask_o(mask));

    pirq_irq_out #(.NUM_SRC(NUM_SRC)) u_irq (
        .clk(clk), .rst_n(rst_n), .status_i(status), .mask_i(mask), .irq_o(irq_o));

    // Purpose: read mux, status at its own address, mask elsewhere
    always_comb begin
        bus_rdata = (bus_addr == A_STATUS) ? status : mask;
    end

    // R6: a direct write to the mask address changes nothing
    p_mask_wr_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_MASK) |=> $stable(mask));

    // R1: the cycle after reset shows the reset state
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (status == '0 && mask == '1 && !irq_o));
endmodule

// File: tb/tb_pirq_ctrl.sv
module tb_pirq_ctrl;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [31:0] src = '0;
    logic        we = 0;
    logic [1:0]  addr = 0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    pirq_ctrl dut (.clk(clk), .rst_n(rst_n), .src_i(src), .bus_we(we),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq));

    // Behavioural reference model
    logic [31:0] m_st, m_mk, m_prev;
    logic        m_irq;
    always @(posedge clk) begin
        logic [31:0] rise, clr, ns, nm;
        if (!rst_n) begin
            m_st = '0; m_mk = '1; m_prev = '0; m_irq = 0;
        end else begin
            rise = src & ~m_prev & 32'hFFFF_FFF0;
            clr  = (we && addr == 2'd0) ? wdata : '0;
            ns   = (((m_st & ~clr) | rise) & 32'hFFFF_FFF0) | (src & 32'hF);
            nm   = m_mk;
            if (we && addr == 2'd2) nm = nm | wdata;
            if (we && addr == 2'd3) nm = nm & ~wdata;
            m_irq = ((m_st & ~m_mk) != 0);
            m_st = ns; m_mk = nm; m_prev = src;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Per-cycle comparison against the model (R7, R8)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R7 irq", {31'd0, irq}, {31'd0, m_irq});
            chk("R8 rdata", rdata, (addr == 2'd0) ? m_st : m_mk);
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        we = 1; addr = a; wdata = d; tick(); we = 0; addr = 0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input logic [31:0] exp);
        addr = a; #1; chk(req, rdata, exp);
    endtask

    initial begin
        repeat (3) tick();
        rd_chk("R1 status reset", 2'd0, 32'h0);
        rd_chk("R1 mask reset", 2'd1, 32'hFFFF_FFFF);
        chk("R1 irq reset", {31'd0, irq}, 32'd0);
        rst_n = 1; tick();
        rd_chk("R1 status after reset", 2'd0, 32'h0);
        addr = 0;
        wr(2'd2, 32'hFFFF_FFFF);
        wr(2'd0, 32'hFFFF_FFFF);

        // R2 level mirror
        src[2] = 1; tick(); tick();
        rd_chk("R2 intx high", 2'd0, 32'h4);
        addr = 0;
        wr(2'd0, 32'hF);
        rd_chk("R2 clear ignored", 2'd0, 32'h4);
        addr = 0;
        src[2] = 0; tick(); tick();
        rd_chk("R2 intx low", 2'd0, 32'h0);
        addr = 0;

        // R3 edge latch with single-cycle pulse
        src[pirq_pkg::BIT_LINK_UP] = 1; tick();
        src[pirq_pkg::BIT_LINK_UP] = 0; tick();
        src[pirq_pkg::BIT_LINK_DOWN] = 1; tick(); tick();
        rd_chk("R3 pulse latched", 2'd0, 32'h5000);
        addr = 0;

        // R4 selective clear; held source does not re-latch
        wr(2'd0, 32'h1000);
        tick();
        rd_chk("R4 cleared bit12 kept bit14", 2'd0, 32'h4000);
        addr = 0;
        wr(2'd0, 32'h4000);
        tick(); tick();
        rd_chk("R4 held source stays clear", 2'd0, 32'h0);
        addr = 0;
        src[pirq_pkg::BIT_LINK_DOWN] = 0; tick();

        // R5 set wins over clear in same cycle
        src[pirq_pkg::BIT_CPL_TMO] = 1;
        wr(2'd0, 32'h0080_0000);
        tick();
        rd_chk("R5 set wins", 2'd0, 32'h0080_0000);
        addr = 0;
        src[pirq_pkg::BIT_CPL_TMO] = 0; tick();

        // R6 mask set/clear/direct write
        wr(2'd3, 32'h0080_0000);
        rd_chk("R6 mask clear", 2'd1, 32'hFF7F_FFFF);
        addr = 0;
        // R7 unmasked pending raises irq after one edge
        tick();
        chk("R7 irq raised", {31'd0, irq}, 32'd1);
        wr(2'd1, 32'h0);
        rd_chk("R6 direct write ignored", 2'd1, 32'hFF7F_FFFF);
        addr = 0;
        wr(2'd2, 32'h0080_0000);
        rd_chk("R6 mask set", 2'd3, 32'hFFFF_FFFF);
        addr = 0;
        tick();
        chk("R7 irq dropped", {31'd0, irq}, 32'd0);

        // R7 intx unmasked drives irq; event pulses with mixed pattern
        wr(2'd3, 32'h0000_0001);
        src = 32'hA5A0_0001; tick();
        src = 32'h0; tick(); tick();
        rd_chk("R3 mixed pattern", 2'd0, 32'hA5A0_0000);
        addr = 0;
        chk("R7 irq after level drop", {31'd0, irq}, 32'd0);
        wr(2'd0, 32'hFFFF_FFFF);
        tick();
        rd_chk("R4 clear all", 2'd0, 32'h0);
        addr = 0;

        // R1 reset mid-run
        src = 32'h0000_1000; tick();
        rst_n = 0; tick(); tick();
        rst_n = 1;
        rd_chk("R1 reset again mask", 2'd1, 32'hFFFF_FFFF);
        rd_chk("R1 reset again status", 2'd0, 32'h0);
        addr = 0;
        tick(); tick();
        src = 0;
        repeat (4) tick();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule